// File: doc/BRIEF.md
# Bridge Control Register File

This block is the word-wide control register bank of a host bridge. It holds twenty-eight 32-bit words: configuration words, general-purpose I/O data and enable words, the interrupt controller's trigger-mode, steering and polarity words, four mailbox words, cache-control words and timing words. The host reaches it through a simple word-addressed bus. Each access moves one full 32-bit word. The word index on the bus equals the byte offset divided by four.

The interrupt-enable word cannot be written directly. Software changes it through two alias words. One sets the enable bits that it writes as ones, and the other clears them. The enable word and the interrupt-status word can only be read. When a write to the general-configuration word takes its soft-reset bit from 0 to 1, the block sends a one-cycle reset request to the system. The enable, trigger-mode and polarity words are brought out as vectors for the interrupt unit.

Top module: `bridge_ctl_regfile`

## Requirements
- R1: The bus index is the byte offset shifted right by two. A read issued with `rd_en` in one cycle shows the addressed word on `rdata` after the next rising edge. `rdata` then holds that value until the next read. A read that coincides with a write to the same index returns the value from before the write.
- R2: After reset, these words hold the listed values (index: value): 0: 0xC40, 1: 0x1384, 2: 0x2BFF8010, 3: 0x255E0091, 4: 0x6140, 7: 0x1FF, 8: 0x1FF, 26: 0x8, 27: 0x10000000. Every other index reads 0.
- R3: Indices 0–11 and 16–27 are plain storage. A write replaces the whole word, and a later read returns it.
- R4: A write to index 12 (enable-set) stores the written value at index 12. It also ORs that value into the enable word at index 14.
- R5: A write to index 13 (enable-clear) stores the written value at index 13. It also clears, in the enable word, every bit that the value has set.
- R6: Writes to index 14 (enable) and index 15 (interrupt status) change nothing. The status word always reads 0.
- R7: Indices 28–31 are undefined. Writes to them change nothing, and reads from them return 0.
- R8: A write to index 1 whose bit 2 is 1, while the stored bit 2 is 0, stores the value. It also drives `rst_req` high for exactly the one cycle after that write's clock edge.
- R9: A write to index 1 requests no reset if bit 2 is already 1 or if the written bit 2 is 0. Such a write still stores the value.
- R10: `irq_enable` always equals the word at index 14. `irq_edge` equals the word at index 9, and `irq_polarity` equals the word at index 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| rd_en | input | 1 | Read strobe for one word |
| addr | input | 5 | Word index (byte offset >> 2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| irq_enable | output | 32 | Interrupt-enable vector |
| irq_edge | output | 32 | Per-source trigger-mode vector (1 = edge) |
| irq_polarity | output | 32 | Per-source polarity vector |

## Verification
The bench sweeps all 32 indices three times: after reset, with one data pattern and with its complement. Every read is compared with a model that is built from the requirements. These sweeps catch a wrong reset constant, a write that reaches an undefined or read-only index, and an alias that overwrites the enable word when it should OR into it or mask it. The enable aliases are run with overlapping masks, so a clear that wiped the whole word or a set that dropped earlier bits would show up. The soft-reset bit is taken from 0 to 1, written as 1 again, and written with its bit at 0. A detector that looked at levels instead of the stored transition would fire too often, and a stretched pulse would still read high one cycle later.

// File: rtl/bcr_pkg.sv
// Shared constants of the bridge control register file: word count,
// special word indices and the reset image. Assumes 32-bit words.
package bcr_pkg;
    localparam int NUM_WORDS   = 28;
    localparam int IDX_GENCFG  = 1;
    localparam int IDX_EDGE    = 9;
    localparam int IDX_POL     = 11;
    localparam int IDX_IEN_SET = 12;
    localparam int IDX_IEN_CLR = 13;
    localparam int IDX_IEN     = 14;
    localparam int IDX_ISR     = 15;
    localparam int SWRST_BIT   = 2;

    // Reset image of one word, by index.
    function automatic logic [31:0] reset_word(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction
endpackage

// File: rtl/bcr_store.sv
// Plain storage words of the register file. One flop word per index,
// except the enable and status words, which are held elsewhere and read
// as zero here. Assumes addr has been range-qualified by the caller.
module bcr_store
    import bcr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] words [NUM_WORDS]
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == IDX_IEN || i == IDX_ISR) begin : g_none
            assign words[i] = '0;
        end else begin : g_flop
            logic [DW-1:0] q;
            // Load the reset image, or take a full-word write to this index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= DW'(reset_word(i));
                else if (wr_en && addr == AW'(i))
                    q <= wdata;
            end
            assign words[i] = q;
        end
    end
endmodule

// File: rtl/bcr_ien.sv
// Interrupt-enable word. Changed only by the set and clear aliases, never
// by a direct write. Assumes at most one strobe per cycle.
module bcr_ien #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_stb,
    input  logic          clr_stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ien
);
    // OR in set bits, or mask out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= '0;
        else if (set_stb)
            ien <= ien | wdata;
        else if (clr_stb)
            ien <= ien & ~wdata;
    end
endmodule

// File: rtl/bcr_swreset.sv
// Soft-reset request generator. Sends a one-cycle pulse when a write to
// the general-config word raises the soft-reset bit. Assumes cur_bit is
// the stored bit from before the write.
module bcr_swreset (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic new_bit,
    input  logic cur_bit,
    output logic rst_req
);
    // Register the 0-to-1 detection, so the output is a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= cfg_wr && new_bit && !cur_bit;
    end
endmodule

// File: rtl/bridge_ctl_regfile.sv
// Bridge control register file top. Decodes the word bus, holds the
// registered read port and exports the interrupt vectors. Assumes full
// 32-bit accesses and at most one of wr_en/rd_en per address per cycle
// (a simultaneous read sees the pre-write value).
module bridge_ctl_regfile
    import bcr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rst_req,
    output logic [DW-1:0] irq_enable,
    output logic [DW-1:0] irq_edge,
    output logic [DW-1:0] irq_polarity
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_WORDS - 1);

    logic          in_range;
    logic [DW-1:0] words [NUM_WORDS];
    logic [DW-1:0] ien;

    assign in_range = (addr <= LAST_IDX);

    bcr_store #(.DW(DW), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en && in_range),
        .addr  (addr),
        .wdata (wdata),
        .words (words)
    );

    bcr_ien #(.DW(DW)) u_ien (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_en && addr == AW'(IDX_IEN_SET)),
        .clr_stb (wr_en && addr == AW'(IDX_IEN_CLR)),
        .wdata   (wdata),
        .ien     (ien)
    );

    bcr_swreset u_swrst (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (wr_en && addr == AW'(IDX_GENCFG)),
        .new_bit (wdata[SWRST_BIT]),
        .cur_bit (words[IDX_GENCFG][SWRST_BIT]),
        .rst_req (rst_req)
    );

    // Registered read port; undefined indices read zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            if (!in_range)
                rdata <= '0;
            else if (addr == AW'(IDX_IEN))
                rdata <= ien;
            else
                rdata <= words[addr];
        end
    end

    assign irq_enable   = ien;
    assign irq_edge     = words[IDX_EDGE];
    assign irq_polarity = words[IDX_POL];
endmodule

// File: rtl/bcr_checker.sv
// Port-level properties of the bridge control register file, bound to
// every instance of the top module.
module bcr_checker #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          rst_req,
    input logic [DW-1:0] irq_enable
);
    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R4
    ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(12)) |=> irq_enable == ($past(irq_enable) | $past(wdata)));
    // R5
    ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(13)) |=> irq_enable == ($past(irq_enable) & ~$past(wdata)));
    // R6
    ien_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == AW'(12) || addr == AW'(13))) |=> $stable(irq_enable));
    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R9
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(wr_en) && $past(addr) == AW'(1) && $past(wdata[2])));
endmodule

bind bridge_ctl_regfile bcr_checker #(.DW(DW), .AW(AW)) u_bcr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rst_req    (rst_req),
    .irq_enable (irq_enable)
);

// File: tb/bridge_ctl_regfile_tb.sv
`timescale 1ns/1ps
module bridge_ctl_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rst_req;
    logic [31:0] irq_enable, irq_edge, irq_polarity;

    int total = 0;
    int bad = 0;
    logic [31:0] m [32];

    always #2 clk = ~clk;

    bridge_ctl_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req),
        .irq_enable(irq_enable), .irq_edge(irq_edge), .irq_polarity(irq_polarity)
    );

    function automatic logic [31:0] rv(input int i);
        case (i)
            0: return 32'hC40;       1: return 32'h1384;
            2: return 32'h2BFF8010;  3: return 32'h255E0091;
            4: return 32'h6140;      7: return 32'h1FF;
            8: return 32'h1FF;       26: return 32'h8;
            27: return 32'h10000000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m[i] = rv(i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        bit pulse;
        pulse = (idx == 1) && d[2] && !m[1][2];
        case (idx)
            12: begin m[12] = d; m[14] = m[14] | d; end
            13: begin m[13] = d; m[14] = m[14] & ~d; end
            14, 15, 28, 29, 30, 31: ;
            default: m[idx] = d;
        endcase
        wr_en = 1'b1; addr = 5'(idx); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rst_req == pulse, pulse ? "R8 pulse" : "R9 no pulse", {31'b0, rst_req}, {31'b0, pulse});
        chk(irq_enable == m[14], "R10 irq_enable", irq_enable, m[14]);
        chk(irq_edge == m[9], "R10 irq_edge", irq_edge, m[9]);
        chk(irq_polarity == m[11], "R10 irq_polarity", irq_polarity, m[11]);
        if (pulse) begin
            @(negedge clk);
            chk(rst_req == 1'b0, "R8 single cycle", {31'b0, rst_req}, 32'h0);
        end
    endtask

    task automatic rd(input int idx, input string req);
        rd_en = 1'b1; addr = 5'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rdata == m[idx], req, rdata, m[idx]);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state of rdata, R2 reset sweep of all indices
        chk(rdata == 32'h0, "R1 rdata reset", rdata, 32'h0);
        chk(rst_req == 1'b0, "R8 rst_req reset", {31'b0, rst_req}, 32'h0);
        for (int i = 0; i < 32; i++) rd(i, (i > 27) ? "R7 undefined read" : "R2 reset value");
        // R3 R6 R7 pattern sweep over every index, then its complement
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 32; i++) begin
                logic [31:0] v;
                v = 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0101);
                if (p == 1) v = ~v;
                if (i == 1) v[2] = 1'b1;
                wr(i, v);
            end
            for (int i = 0; i < 32; i++)
                rd(i, (i == 14 || i == 15) ? "R6 read-only" : (i > 27) ? "R7 undefined" : "R3 storage");
        end
        // R4 R5 overlapping set/clear masks
        wr(13, 32'hFFFF_FFFF);
        rd(14, "R5 clear all");
        wr(12, 32'h0000_00F0); wr(12, 32'h0000_0F00);
        rd(14, "R4 set accumulates");
        wr(13, 32'h0000_0330);
        rd(14, "R5 partial clear");
        rd(12, "R4 set stored"); rd(13, "R5 clear stored");
        wr(14, 32'hFFFF_FFFF); rd(14, "R6 enable write ignored");
        wr(15, 32'hFFFF_FFFF); rd(15, "R6 status write ignored");
        // R1 hold: idle cycles keep rdata
        begin
            logic [31:0] held;
            held = rdata;
            repeat (3) @(negedge clk);
            chk(rdata == held, "R1 rdata holds", rdata, held);
        end
        // R1 read-during-write returns old value
        begin
            logic [31:0] old;
            old = m[5];
            wr_en = 1'b1; rd_en = 1'b1; addr = 5'd5; wdata = 32'h1234_5678;
            m[5] = 32'h1234_5678;
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            chk(rdata == old, "R1 read before write", rdata, old);
            rd(5, "R1 new value");
        end
        // R8 R9 soft-reset bit transitions
        wr(1, 32'h0000_0000);
        wr(1, 32'h0000_0004);
        wr(1, 32'h0000_0004);
        wr(1, 32'hFFFF_FFFB);
        wr(1, 32'hFFFF_FFFF);
        rd(1, "R8 value stored");
        // R2 second reset restores image
        do_reset();
        for (int i = 0; i < 32; i++) rd(i, "R2 reset after use");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule